// File: doc/BRIEF.md
# Floating-Point Add-Subtract Butterfly

This block takes two single-precision (32-bit IEEE-754) operands, A and B, and forms both their sum A+B and their difference B−A in one pass, as a radix-2 FFT or DCT butterfly needs. A one-bit form select decides the output order. In add-form the sum is the primary result. In subtract-form the difference is the primary result. The other value always leaves as the secondary result.

Each operation carries a 7-bit primary destination index and a vector length. The block returns a second destination index for the secondary result, equal to the primary index plus the vector length. A one-bit record flag rides alongside the operation and comes out unchanged with its results.

The datapath has three registered stages: operand classify/compare/align, twin significand adders, and normalize/round/pack. It uses valid/ready handshakes on both sides, and a full pipeline pushes back on the input. Rounding is round-to-nearest-even only. Subnormal inputs and outputs are flushed to zero.

Top module: `fpbf_butterfly`

## Requirements
- R1: With `in_sub`=0 (add-form), `out_pri` is the rounded A+B and `out_sec` is the rounded B−A.
- R2: With `in_sub`=1 (subtract-form), `out_pri` is the rounded B−A and `out_sec` is the rounded A+B.
- R3: The difference is always the second operand minus the first. For A=1.0 and B=3.0 it is +2.0 (0x40000000), never −2.0.
- R4: `out_dst_pri` equals the accepted `in_dst`. `out_dst_sec` equals (`in_dst` + `in_vl`) mod 128.
- R5: `out_rec` equals the `in_rec` value accepted with the same operation.
- R6: Results are rounded to nearest with ties to even. 1.0 + 2^-24 gives 0x3F800000. 1.0 + 1.5·2^-24 gives 0x3F800001. 0x3F800001 + 2^-24 gives 0x3F800002.
- R7: A finite result whose exponent exceeds the largest normal becomes infinity (exponent 0xFF, fraction 0) with the result's sign. An infinite operand gives an infinity of the matching sign.
- R8: Any NaN operand gives 0x7FC00000 on both outputs. A sum or difference of opposite infinities also gives 0x7FC00000.
- R9: An input with exponent field 0 acts as a zero of its own sign. A rounded result below the smallest normal becomes a zero carrying the result's sign. No output ever has exponent 0 with a nonzero fraction.
- R10: An exactly cancelling sum or difference of nonzero values is +0. (−0)+(−0) is −0, and (−0)−(−0) is +0.
- R11: An operation accepted at clock edge k shows `out_valid` after edge k+2. With `out_ready` held high, one operation is accepted every cycle with no `in_ready` drop.
- R12: While `out_valid` is high and `out_ready` low, all outputs hold. Results leave in acceptance order with none lost. With three operations held inside, `in_ready` is low.
- R13: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_sub | input | 1 | Form select: 0 add-form, 1 subtract-form |
| in_rec | input | 1 | Record flag carried with the operation |
| in_a | input | 32 | First operand A |
| in_b | input | 32 | Second operand B |
| in_dst | input | IDX_W | Primary destination index |
| in_vl | input | IDX_W | Current vector length |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the beat |
| out_pri | output | 32 | Primary result |
| out_sec | output | 32 | Secondary result |
| out_dst_pri | output | IDX_W | Primary destination index |
| out_dst_sec | output | IDX_W | Secondary destination index |
| out_rec | output | 1 | Record flag |

## Verification
A new operation can enter the pipeline in the same cycle that a stalled result beat is held or released. So input acceptance and output backpressure overlap. The bench provokes this by stalling `out_ready` at random while it offers operations with random gaps, including a phase where the output is held off until three operations are inside. It judges the outcome against a queue of expected beats computed from a real-valued model with explicit round-to-nearest-even, and it compares every held beat with its previous value. Directed corner operands for ties, overflow, NaN, flushing and cancellation pass through the same contested path.

// File: rtl/fpbf_pkg.sv
`timescale 1ns/1ps
package fpbf_pkg;
  localparam int FP_W  = 32;
  localparam int EXP_W = 8;
  localparam int MAN_W = FP_W - EXP_W - 1;
  localparam int SIG_W = MAN_W + 1;
  localparam int GRS_W = 3;
  localparam int ALN_W = SIG_W + GRS_W;
  localparam int RAW_W = ALN_W + 1;
  localparam int LZ_W  = $clog2(RAW_W);
  localparam int EW    = EXP_W + 2;
  localparam logic [EXP_W-1:0] EXP_TOP = '1;
  localparam logic [FP_W-1:0]  QNAN    = {1'b0, EXP_TOP, 1'b1, {(MAN_W-1){1'b0}}};

  typedef struct packed {
    logic             sa;
    logic             sb;
    logic             a_big;
    logic [EXP_W-1:0] exp_big;
    logic [ALN_W-1:0] sig_big;
    logic [ALN_W-1:0] sig_small;
    logic             special;
    logic [FP_W-1:0]  sum_sp;
    logic [FP_W-1:0]  dif_sp;
  } aln_t;

  typedef struct packed {
    logic             sign;
    logic             eff_sub;
    logic [EXP_W-1:0] exp;
    logic [RAW_W-1:0] mag;
  } raw_t;
endpackage

// File: rtl/fpbf_align.sv
`timescale 1ns/1ps
module fpbf_align
  import fpbf_pkg::*;
(
  input  logic [FP_W-1:0] opa,
  input  logic [FP_W-1:0] opb,
  output aln_t            aln
);
  logic [EXP_W-1:0] ea, eb, e_small, dexp;
  logic [MAN_W-1:0] ma, mb;
  logic             za, zb, a_nan, b_nan, a_inf, b_inf;
  logic [FP_W-2:0]  mag_a, mag_b;
  logic [SIG_W-1:0] siga, sigb, sig_s;
  logic [ALN_W-1:0] ext_s, shf_s, mask_s;
  logic             sticky;

  always_comb begin
    ea    = opa[FP_W-2 -: EXP_W];
    eb    = opb[FP_W-2 -: EXP_W];
    ma    = opa[MAN_W-1:0];
    mb    = opb[MAN_W-1:0];
    za    = (ea == '0);
    zb    = (eb == '0);
    a_nan = (ea == EXP_TOP) && (ma != '0);
    b_nan = (eb == EXP_TOP) && (mb != '0);
    a_inf = (ea == EXP_TOP) && (ma == '0);
    b_inf = (eb == EXP_TOP) && (mb == '0);
    siga  = za ? '0 : {1'b1, ma};
    sigb  = zb ? '0 : {1'b1, mb};
    mag_a = za ? '0 : opa[FP_W-2:0];
    mag_b = zb ? '0 : opb[FP_W-2:0];

    aln.sa    = opa[FP_W-1];
    aln.sb    = opb[FP_W-1];
    aln.a_big = (mag_a >= mag_b);
    if (aln.a_big) begin
      aln.exp_big = za ? '0 : ea;
      e_small     = zb ? '0 : eb;
      aln.sig_big = {siga, {GRS_W{1'b0}}};
      sig_s       = sigb;
    end else begin
      aln.exp_big = zb ? '0 : eb;
      e_small     = za ? '0 : ea;
      aln.sig_big = {sigb, {GRS_W{1'b0}}};
      sig_s       = siga;
    end

    dexp  = aln.exp_big - e_small;
    ext_s = {sig_s, {GRS_W{1'b0}}};
    if (dexp >= EXP_W'(ALN_W)) begin
      shf_s  = '0;
      mask_s = '1;
      sticky = |sig_s;
    end else begin
      shf_s  = ext_s >> dexp;
      mask_s = (ALN_W'(1) << dexp) - ALN_W'(1);
      sticky = |(ext_s & mask_s);
    end
    aln.sig_small = {shf_s[ALN_W-1:1], shf_s[0] | sticky};

    aln.special = a_nan | b_nan | a_inf | b_inf;
    aln.sum_sp  = QNAN;
    aln.dif_sp  = QNAN;
    if (a_nan || b_nan) begin
      aln.sum_sp = QNAN;
      aln.dif_sp = QNAN;
    end else if (a_inf && b_inf) begin
      aln.sum_sp = (opa[FP_W-1] == opb[FP_W-1]) ? {opa[FP_W-1], EXP_TOP, {MAN_W{1'b0}}} : QNAN;
      aln.dif_sp = (opa[FP_W-1] != opb[FP_W-1]) ? {opb[FP_W-1], EXP_TOP, {MAN_W{1'b0}}} : QNAN;
    end else if (a_inf) begin
      aln.sum_sp = {opa[FP_W-1], EXP_TOP, {MAN_W{1'b0}}};
      aln.dif_sp = {~opa[FP_W-1], EXP_TOP, {MAN_W{1'b0}}};
    end else if (b_inf) begin
      aln.sum_sp = {opb[FP_W-1], EXP_TOP, {MAN_W{1'b0}}};
      aln.dif_sp = {opb[FP_W-1], EXP_TOP, {MAN_W{1'b0}}};
    end
  end
endmodule

// File: rtl/fpbf_addsub.sv
`timescale 1ns/1ps
module fpbf_addsub
  import fpbf_pkg::*;
(
  input  aln_t aln,
  output raw_t sum_raw,
  output raw_t dif_raw
);
  logic [RAW_W-1:0] mag_add, mag_sub;
  logic             sum_is_add, dif_is_add;

  always_comb begin
    mag_add    = {1'b0, aln.sig_big} + {1'b0, aln.sig_small};
    mag_sub    = {1'b0, aln.sig_big - aln.sig_small};
    sum_is_add = (aln.sa == aln.sb);
    dif_is_add = (aln.sa != aln.sb);

    sum_raw.exp     = aln.exp_big;
    sum_raw.eff_sub = ~sum_is_add;
    sum_raw.mag     = sum_is_add ? mag_add : mag_sub;
    sum_raw.sign    = sum_is_add ? aln.sa : (aln.a_big ? aln.sa : aln.sb);

    dif_raw.exp     = aln.exp_big;
    dif_raw.eff_sub = ~dif_is_add;
    dif_raw.mag     = dif_is_add ? mag_add : mag_sub;
    dif_raw.sign    = dif_is_add ? aln.sb : (aln.a_big ? ~aln.sa : aln.sb);
  end
endmodule

// File: rtl/fpbf_round.sv
`timescale 1ns/1ps
module fpbf_round
  import fpbf_pkg::*;
(
  input  raw_t            raw,
  input  logic            spec,
  input  logic [FP_W-1:0] spec_val,
  output logic [FP_W-1:0] res
);
  logic [LZ_W-1:0]  lead, sh;
  logic [ALN_W-1:0] nrm;
  logic [EW-1:0]    e_n, e_f;
  logic [SIG_W:0]   m25;
  logic             up;
  logic [MAN_W-1:0] frac;

  always_comb begin
    lead = '0;
    for (int i = 0; i < RAW_W; i++) begin
      if (raw.mag[i]) lead = LZ_W'(i);
    end
    sh = LZ_W'(ALN_W - 1) - lead;
    if (raw.mag[RAW_W-1]) nrm = {raw.mag[RAW_W-1:2], |raw.mag[1:0]};
    else                  nrm = raw.mag[ALN_W-1:0] << sh;
    e_n  = {2'b00, raw.exp} + {{(EW-LZ_W){1'b0}}, lead} - EW'(ALN_W - 1);
    up   = nrm[GRS_W-1] & (nrm[GRS_W-2] | nrm[0] | nrm[GRS_W]);
    m25  = {1'b0, nrm[ALN_W-1:GRS_W]} + {{SIG_W{1'b0}}, up};
    e_f  = m25[SIG_W] ? e_n + EW'(1) : e_n;
    frac = m25[SIG_W] ? m25[SIG_W-1:1] : m25[MAN_W-1:0];

    if (spec)
      res = spec_val;
    else if (raw.mag == '0)
      res = {raw.sign & ~raw.eff_sub, {(FP_W-1){1'b0}}};
    else if ($signed(e_f) >= $signed(EW'(EXP_TOP)))
      res = {raw.sign, EXP_TOP, {MAN_W{1'b0}}};
    else if ($signed(e_f) <= $signed(EW'(0)))
      res = {raw.sign, {(FP_W-1){1'b0}}};
    else
      res = {raw.sign, e_f[EXP_W-1:0], frac};
  end
endmodule

// File: rtl/fpbf_butterfly.sv
`timescale 1ns/1ps
module fpbf_butterfly
  import fpbf_pkg::*;
#(
  parameter int IDX_W = 7
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_sub,
  input  logic             in_rec,
  input  logic [FP_W-1:0]  in_a,
  input  logic [FP_W-1:0]  in_b,
  input  logic [IDX_W-1:0] in_dst,
  input  logic [IDX_W-1:0] in_vl,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [FP_W-1:0]  out_pri,
  output logic [FP_W-1:0]  out_sec,
  output logic [IDX_W-1:0] out_dst_pri,
  output logic [IDX_W-1:0] out_dst_sec,
  output logic             out_rec
);
  localparam int NRES = 2;

  logic rst_q1, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_s  <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_s  <= rst_q1;
    end
  end

  logic en1, en2, en3, ld1, ld2, ld3;
  logic s1_v, s2_v, s3_v, s1_v_nxt, s2_v_nxt, s3_v_nxt;

  always_comb begin
    en3      = ~s3_v | out_ready;
    en2      = ~s2_v | en3;
    en1      = ~s1_v | en2;
    ld1      = en1 & in_valid & rst_s;
    ld2      = en2 & s1_v;
    ld3      = en3 & s2_v;
    s1_v_nxt = en1 ? (in_valid & rst_s) : s1_v;
    s2_v_nxt = en2 ? s1_v : s2_v;
    s3_v_nxt = en3 ? s2_v : s3_v;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
      s3_v <= 1'b0;
    end else begin
      s1_v <= s1_v_nxt;
      s2_v <= s2_v_nxt;
      s3_v <= s3_v_nxt;
    end
  end

  // stage 1: classify, compare, align
  aln_t             aln_c, s1_aln;
  logic             s1_sub, s1_rec;
  logic [IDX_W-1:0] s1_dst, s1_dst2, dst2_c;

  fpbf_align u_align (.opa(in_a), .opb(in_b), .aln(aln_c));

  always_comb dst2_c = in_dst + in_vl;

  always_ff @(posedge clk) begin
    if (ld1) begin
      s1_aln  <= aln_c;
      s1_sub  <= in_sub;
      s1_rec  <= in_rec;
      s1_dst  <= in_dst;
      s1_dst2 <= dst2_c;
    end
  end

  // stage 2: twin significand adders
  raw_t             sum_c, dif_c, s2_sum, s2_dif;
  logic             s2_spec, s2_sub, s2_rec;
  logic [FP_W-1:0]  s2_sum_sp, s2_dif_sp;
  logic [IDX_W-1:0] s2_dst, s2_dst2;

  fpbf_addsub u_addsub (.aln(s1_aln), .sum_raw(sum_c), .dif_raw(dif_c));

  always_ff @(posedge clk) begin
    if (ld2) begin
      s2_sum    <= sum_c;
      s2_dif    <= dif_c;
      s2_spec   <= s1_aln.special;
      s2_sum_sp <= s1_aln.sum_sp;
      s2_dif_sp <= s1_aln.dif_sp;
      s2_sub    <= s1_sub;
      s2_rec    <= s1_rec;
      s2_dst    <= s1_dst;
      s2_dst2   <= s1_dst2;
    end
  end

  // stage 3: one rounder per result
  raw_t             rnd_raw [NRES];
  logic [FP_W-1:0]  rnd_sp  [NRES];
  logic [FP_W-1:0]  rnd_res [NRES];
  logic [FP_W-1:0]  pri_c, sec_c;

  always_comb begin
    rnd_raw[0] = s2_sum;
    rnd_raw[1] = s2_dif;
    rnd_sp[0]  = s2_sum_sp;
    rnd_sp[1]  = s2_dif_sp;
  end

  for (genvar g = 0; g < NRES; g++) begin : g_rnd
    fpbf_round u_round (
      .raw      (rnd_raw[g]),
      .spec     (s2_spec),
      .spec_val (rnd_sp[g]),
      .res      (rnd_res[g])
    );
  end

  always_comb begin
    pri_c = s2_sub ? rnd_res[1] : rnd_res[0];
    sec_c = s2_sub ? rnd_res[0] : rnd_res[1];
  end

  always_ff @(posedge clk) begin
    if (ld3) begin
      out_pri     <= pri_c;
      out_sec     <= sec_c;
      out_rec     <= s2_rec;
      out_dst_pri <= s2_dst;
      out_dst_sec <= s2_dst2;
    end
  end

  assign out_valid = s3_v;
  assign in_ready  = en1 & rst_s;

  // R12
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_s)
    out_valid && !out_ready |=> out_valid && $stable(out_pri) && $stable(out_sec)
      && $stable(out_dst_pri) && $stable(out_dst_sec) && $stable(out_rec));

  // R12
  stall_src_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !in_ready |-> s1_v && s2_v && s3_v && !out_ready);

  // R11
  take_in_chk: assert property (@(posedge clk) disable iff (!rst_s)
    in_valid && in_ready |=> s1_v);

  // R9
  no_subn_pri_chk: assert property (@(posedge clk) disable iff (!rst_s)
    out_valid |-> (out_pri[FP_W-2 -: EXP_W] != '0) || (out_pri[MAN_W-1:0] == '0));

  // R9
  no_subn_sec_chk: assert property (@(posedge clk) disable iff (!rst_s)
    out_valid |-> (out_sec[FP_W-2 -: EXP_W] != '0) || (out_sec[MAN_W-1:0] == '0));
endmodule

// File: tb/tb_fpbf_butterfly.sv
`timescale 1ns/1ps
module tb_fpbf_butterfly;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, in_sub, in_rec, out_valid, out_ready, out_rec;
  logic [31:0] in_a, in_b, out_pri, out_sec;
  logic [6:0]  in_dst, in_vl, out_dst_pri, out_dst_sec;

  always #2.5 clk = ~clk;

  fpbf_butterfly #(.IDX_W(7)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sub(in_sub), .in_rec(in_rec), .in_a(in_a), .in_b(in_b),
    .in_dst(in_dst), .in_vl(in_vl), .out_valid(out_valid), .out_ready(out_ready),
    .out_pri(out_pri), .out_sec(out_sec), .out_dst_pri(out_dst_pri),
    .out_dst_sec(out_dst_sec), .out_rec(out_rec)
  );

  typedef struct packed {
    logic [31:0] a, b;
    logic        sub, rec;
    logic [6:0]  dst, vl;
    logic [31:0] tag;
  } stim_t;

  typedef struct packed {
    logic [31:0] pri, sec;
    logic [6:0]  dp, ds;
    logic        rec;
    logic [31:0] tag;
  } exp_t;

  stim_t stim_q[$];
  exp_t  exp_q[$];
  int    total = 0;
  int    bad   = 0;

  task automatic chk(input logic [31:0] tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic real f2r(input logic [31:0] x);
    logic [10:0] e11;
    if (x[30:23] == 8'd0) return $bitstoreal({x[31], 63'd0});
    e11 = {3'd0, x[30:23]} + 11'd896;
    return $bitstoreal({x[31], e11, x[22:0], 29'd0});
  endfunction

  function automatic logic [31:0] r2f(input real r);
    logic [63:0] d;
    logic [24:0] m;
    logic [28:0] rem;
    int          e;
    d = $realtobits(r);
    if (d[62:0] == 63'd0) return {d[63], 31'd0};
    e   = int'(d[62:52]) - 896;
    m   = {2'b01, d[51:29]};
    rem = d[28:0];
    if (rem > 29'h10000000 || (rem == 29'h10000000 && m[0])) m = m + 25'd1;
    if (m[24]) begin e++; m = m >> 1; end
    if (e >= 255) return {d[63], 8'hFF, 23'd0};
    if (e <= 0)   return {d[63], 31'd0};
    return {d[63], 8'(e), m[22:0]};
  endfunction

  function automatic logic [31:0] ref_add(input logic [31:0] x, input logic [31:0] y);
    logic xn, yn, xi, yi;
    xn = (x[30:23] == 8'hFF) && (x[22:0] != 0);
    yn = (y[30:23] == 8'hFF) && (y[22:0] != 0);
    xi = (x[30:23] == 8'hFF) && (x[22:0] == 0);
    yi = (y[30:23] == 8'hFF) && (y[22:0] == 0);
    if (xn || yn) return 32'h7FC00000;
    if (xi && yi) return (x[31] == y[31]) ? x : 32'h7FC00000;
    if (xi) return x;
    if (yi) return y;
    return r2f(f2r(x) + f2r(y));
  endfunction

  function automatic exp_t model(input stim_t s);
    exp_t        e;
    logic [31:0] sm, df;
    sm    = ref_add(s.a, s.b);
    df    = ref_add(s.b, s.a ^ 32'h80000000);
    e.pri = s.sub ? df : sm;
    e.sec = s.sub ? sm : df;
    e.dp  = s.dst;
    e.ds  = s.dst + s.vl;
    e.rec = s.rec;
    e.tag = s.tag;
    return e;
  endfunction

  task automatic drive(input stim_t s);
    in_a = s.a; in_b = s.b; in_sub = s.sub; in_rec = s.rec; in_dst = s.dst; in_vl = s.vl;
  endtask

  task automatic check_beat();
    exp_t e;
    if (exp_q.size() == 0) begin
      chk("R12", 32'd1, 32'd0);
      return;
    end
    e = exp_q.pop_front();
    chk(e.tag, out_pri, e.pri);
    chk(e.tag, out_sec, e.sec);
    chk("R4", {25'd0, out_dst_pri}, {25'd0, e.dp});
    chk("R4", {25'd0, out_dst_sec}, {25'd0, e.ds});
    chk("R5", {31'd0, out_rec}, {31'd0, e.rec});
  endtask

  task automatic add_dir(input logic [31:0] a, input logic [31:0] b, input logic sub,
                         input logic [31:0] tag);
    stim_t s;
    s.a = a; s.b = b; s.sub = sub; s.rec = $urandom_range(1);
    s.dst = 7'($urandom); s.vl = 7'($urandom); s.tag = tag;
    stim_q.push_back(s);
  endtask

  task automatic run_stream(input int gap, input int stall, input bit full_rate);
    bit          acc = 0, held = 0;
    int          guard = 0, blocked = 0;
    stim_t       cur;
    logic [31:0] h_pri, h_sec;
    logic [6:0]  h_dp, h_ds;
    logic        h_rec;
    cur = '0;
    while (!(stim_q.size() == 0 && !in_valid && exp_q.size() == 0) && guard < 40000) begin
      @(negedge clk);
      guard++;
      if (acc) begin in_valid = 1'b0; acc = 0; end
      if (!in_valid && stim_q.size() > 0 && $urandom_range(99) >= gap) begin
        cur = stim_q.pop_front();
        drive(cur);
        in_valid = 1'b1;
      end
      out_ready = ($urandom_range(99) >= stall);
      #1;
      if (held) begin
        chk("R12", {31'd0, out_valid}, 32'd1);
        chk("R12", out_pri, h_pri);
        chk("R12", out_sec, h_sec);
        chk("R12", {24'd0, out_dst_pri, out_rec}, {24'd0, h_dp, h_rec});
        chk("R12", {25'd0, out_dst_sec}, {25'd0, h_ds});
      end
      held = out_valid && !out_ready;
      if (held) begin
        h_pri = out_pri; h_sec = out_sec; h_dp = out_dst_pri; h_ds = out_dst_sec; h_rec = out_rec;
      end
      if (out_valid && out_ready) check_beat();
      if (in_valid && !in_ready && full_rate) blocked++;
      if (in_valid && in_ready) begin
        exp_q.push_back(model(cur));
        acc = 1;
      end
    end
    if (full_rate) chk("R11", blocked, 0);
    chk("R12", exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    stim_t s;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_a = '0; in_b = '0; in_sub = 1'b0; in_rec = 1'b0; in_dst = '0; in_vl = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R13 reset state
    chk("R13", {31'd0, out_valid}, 32'd0);
    chk("R13", {31'd0, in_ready}, 32'd1);

    // R11 latency: accept, then low, low, high on successive negedges
    @(negedge clk);
    out_ready = 1'b1;
    s = '{a: 32'h3F800000, b: 32'h40400000, sub: 1'b0, rec: 1'b1, dst: 7'd120, vl: 7'd15, tag: "R3"};
    drive(s); in_valid = 1'b1;
    #1 chk("R11", {31'd0, in_ready}, 32'd1);
    @(negedge clk) in_valid = 1'b0;
    #1 chk("R11", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    #1 chk("R11", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    #1 chk("R11", {31'd0, out_valid}, 32'd1);
    // R3 with fixed numbers, R4 wrap 120+15 = 7
    chk("R3", out_pri, 32'h40800000);
    chk("R3", out_sec, 32'h40000000);
    chk("R4", {25'd0, out_dst_sec}, 32'd7);
    chk("R5", {31'd0, out_rec}, 32'd1);
    @(negedge clk);

    // R12 fill while output stalled: three taken, fourth refused
    out_ready = 1'b0;
    for (int i = 0; i < 4; i++) begin
      s = '{a: 32'h40000000 + 32'(i), b: 32'hC0800000, sub: 1'(i), rec: 1'b0,
            dst: 7'(i), vl: 7'd3, tag: (i % 2 == 1) ? "R2" : "R1"};
      drive(s); in_valid = 1'b1;
      #1;
      if (i < 3) begin
        chk("R12", {31'd0, in_ready}, 32'd1);
        exp_q.push_back(model(s));
      end else begin
        chk("R12", {31'd0, in_ready}, 32'd0);
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    run_stream(0, 0, 1'b0);

    // directed corner cases
    add_dir(32'h3F800000, 32'h33800000, 1'b0, "R6");
    add_dir(32'h3F800000, 32'h33C00000, 1'b0, "R6");
    add_dir(32'h3F800001, 32'h33800000, 1'b1, "R6");
    add_dir(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, "R7");
    add_dir(32'hFF7FFFFF, 32'hFF7FFFFF, 1'b1, "R7");
    add_dir(32'h7F800000, 32'h3F800000, 1'b0, "R7");
    add_dir(32'h3F800000, 32'hFF800000, 1'b1, "R7");
    add_dir(32'h7F800000, 32'hFF800000, 1'b0, "R8");
    add_dir(32'h7F800000, 32'h7F800000, 1'b1, "R8");
    add_dir(32'h7F800001, 32'h3F800000, 1'b0, "R8");
    add_dir(32'h40000000, 32'hFFC00000, 1'b1, "R8");
    add_dir(32'h00000001, 32'h3F800000, 1'b0, "R9");
    add_dir(32'h00400000, 32'h80000000, 1'b1, "R9");
    add_dir(32'h00800001, 32'h00800000, 1'b0, "R9");
    add_dir(32'h80800000, 32'h00800003, 1'b1, "R9");
    add_dir(32'h3F800000, 32'hBF800000, 1'b0, "R10");
    add_dir(32'h3F800000, 32'h3F800000, 1'b1, "R10");
    add_dir(32'h80000000, 32'h80000000, 1'b0, "R10");
    add_dir(32'h00000000, 32'h80000000, 1'b1, "R10");
    run_stream(30, 40, 1'b0);

    // R11 full rate with out_ready held high
    for (int i = 0; i < 24; i++) add_dir($urandom, $urandom, 1'($urandom_range(1)), "R11");
    run_stream(0, 0, 1'b1);

    // random mix, R1 and R2
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a, b;
      logic        sb;
      a = $urandom;
      b = $urandom;
      sb = 1'($urandom_range(1));
      case ($urandom_range(3))
        0: ;
        1: b = {b[31], a[30:23] + 8'($urandom_range(2)), b[22:0]};
        2: b = a ^ {sb, 31'd0};
        default: b = {b[31], 8'($urandom_range(30)), b[22:0]};
      endcase
      s.a = a; s.b = b; s.sub = 1'($urandom_range(1)); s.rec = 1'($urandom_range(1));
      s.dst = 7'($urandom); s.vl = 7'($urandom);
      s.tag = s.sub ? "R2" : "R1";
      stim_q.push_back(s);
    end
    run_stream(20, 35, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule